// File: doc/BRIEF.md
# Classification action resolver

This block sits after the rule lookup of a switch classifier. It takes the action record of the rule that matched a frame, together with the results that the rest of the pipeline has already produced for that frame, and turns them into the final per-frame decisions. The pipeline results are the base forwarding port map, the C-VLAN membership port map, the CoS traffic class, the CPU port number, the default learn decision, and a flag saying whether some egress port is still left after later filtering.

Each action group in the record has its own small code. The block merges them under fixed override rules. A non-zero snooping code masks the forwarding code. The learning code can depend on the final port map that the forwarding code produced. When no rule hit, every output takes its default. All decisions come from one layer of combinational logic, and one output register stage holds them.

Top module: `class_action_resolver`

## Requirements
- R1: When `hit_i` is low, the outputs are the defaults: port map = `base_map_i & cvlan_map_i`, learn = `learn_dflt_i`, class = `cos_tc_i`, both meters off with IDs 0, and all flags, the multicast flag and the snoop code 0.
- R2: Learning code (2 bits): 0 passes `learn_dflt_i` through; 1 learns only when `egr_left_i` is high and the final port map is non-zero; 2 never learns; 3 always learns.
- R3: Forwarding codes 0 and 1, and every code from 9 to 15, give the default map `base_map_i & cvlan_map_i`.
- R4: Forwarding code 2 (discard) gives an all-zero port map.
- R5: Forwarding code 3 gives a map with only bit `cpu_port_i` set. Bit n of every map stands for port n.
- R6: Forwarding code 4 gives `alt_map_i` unchanged.
- R7: Forwarding code 7 uses `alt_map_i` in place of the C-VLAN component, giving `base_map_i & alt_map_i`.
- R8: Forwarding code 8 ANDs `alt_map_i` into the default map, giving `base_map_i & cvlan_map_i & alt_map_i`.
- R9: Forwarding codes 5 and 6 give the default map and raise `mcast_o`. All other codes leave `mcast_o` low.
- R10: A non-zero snooping code (3 bits, 0 to 7) is passed to `snoop_o` and makes the resolver ignore the forwarding code, so the map is the default and `mcast_o` is low.
- R11: Class code 2 selects `alt_tc_i`. Codes 0, 1 and 3 select `cos_tc_i`.
- R12: Meter code 2 enables meter A with ID `meter_id_i`. Code 3 also enables meter B with ID `meter_id_i + 1`, which wraps modulo the ID width. Codes 0 and 1 enable neither meter. A disabled meter reports ID 0.
- R13: The interrupt, timestamp, critical-frame, cross-state and cross-VLAN outputs are each high only for their code 2 (2-bit codes). Codes 0, 1 and 3 leave them low.
- R14: Every output is registered once, so it appears one clock after its inputs, with `valid_o` following `valid_i`. The reset state is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Frame decision strobe |
| hit_i | input | 1 | A rule matched this frame |
| snoop_act_i | input | 3 | Snooping action code |
| fwd_act_i | input | 4 | Forwarding action code |
| alt_map_i | input | NPORT | Rule's alternate port map |
| learn_act_i | input | 2 | Learning action code |
| tc_act_i | input | 2 | Traffic class action code |
| alt_tc_i | input | TCW | Rule's alternate class |
| meter_act_i | input | 2 | Meter action code |
| meter_id_i | input | MIDW | Rule's meter ID |
| irq_act_i | input | 2 | Interrupt action code |
| tstamp_act_i | input | 2 | Timestamp action code |
| crit_act_i | input | 2 | Critical-frame action code |
| xstate_act_i | input | 2 | Cross-state action code |
| xvlan_act_i | input | 2 | Cross-VLAN action code |
| base_map_i | input | NPORT | Default forwarding port map |
| cvlan_map_i | input | NPORT | C-VLAN membership port map |
| cos_tc_i | input | TCW | CoS traffic class |
| cpu_port_i | input | PW | CPU port number |
| learn_dflt_i | input | 1 | Default learn decision |
| egr_left_i | input | 1 | Some egress port remains after later filtering |
| valid_o | output | 1 | Registered strobe |
| port_map_o | output | NPORT | Final egress map |
| learn_o | output | 1 | Learn the source address |
| tc_o | output | TCW | Final traffic class |
| mtr_a_en_o | output | 1 | Meter A assigned |
| mtr_a_id_o | output | MIDW | Meter A ID |
| mtr_b_en_o | output | 1 | Meter B assigned |
| mtr_b_id_o | output | MIDW | Meter B ID |
| mcast_o | output | 1 | Treat the frame as multicast |
| snoop_o | output | 3 | Snooping class |
| irq_o | output | 1 | Interrupt event |
| tstamp_o | output | 1 | Store timestamps |
| crit_o | output | 1 | Critical frame |
| xstate_o | output | 1 | Bypass port-state filtering |
| xvlan_o | output | 1 | Bypass VLAN filtering |

## Verification
The assertions check on every cycle the relations that can be seen in a single step. These are: discard gives an empty map, a CPU redirect sets exactly one port, the learning codes 2 and 3 are forced, meter B appears only together with meter A and carries the next ID, a snooping frame never raises the multicast flag, and a miss passes the learn and class defaults through. Only the bench's scenarios can show the full merge for each code. That covers the code 7 and code 8 map arithmetic, the code 1 learn decision that depends on the final map, the unused codes falling back to the default, and the one-cycle alignment of every field across long runs of frames, which the reference model compares on every clock.

// File: rtl/class_action_resolver.sv
module class_action_resolver #(
  parameter int NPORT = 8,
  parameter int TCW   = 4,
  parameter int MIDW  = 5,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             hit_i,
  input  logic [2:0]       snoop_act_i,
  input  logic [3:0]       fwd_act_i,
  input  logic [NPORT-1:0] alt_map_i,
  input  logic [1:0]       learn_act_i,
  input  logic [1:0]       tc_act_i,
  input  logic [TCW-1:0]   alt_tc_i,
  input  logic [1:0]       meter_act_i,
  input  logic [MIDW-1:0]  meter_id_i,
  input  logic [1:0]       irq_act_i,
  input  logic [1:0]       tstamp_act_i,
  input  logic [1:0]       crit_act_i,
  input  logic [1:0]       xstate_act_i,
  input  logic [1:0]       xvlan_act_i,
  input  logic [NPORT-1:0] base_map_i,
  input  logic [NPORT-1:0] cvlan_map_i,
  input  logic [TCW-1:0]   cos_tc_i,
  input  logic [PW-1:0]    cpu_port_i,
  input  logic             learn_dflt_i,
  input  logic             egr_left_i,
  output logic             valid_o,
  output logic [NPORT-1:0] port_map_o,
  output logic             learn_o,
  output logic [TCW-1:0]   tc_o,
  output logic             mtr_a_en_o,
  output logic [MIDW-1:0]  mtr_a_id_o,
  output logic             mtr_b_en_o,
  output logic [MIDW-1:0]  mtr_b_id_o,
  output logic             mcast_o,
  output logic [2:0]       snoop_o,
  output logic             irq_o,
  output logic             tstamp_o,
  output logic             crit_o,
  output logic             xstate_o,
  output logic             xvlan_o
);

  localparam logic [1:0] CODE_ON = 2'd2;

  logic [NPORT-1:0] dflt_map, cpu_map, map_d;
  logic [3:0]       fwd_eff;
  logic             mcast_d, learn_d;
  logic [TCW-1:0]   tc_d;
  logic             ma_en_d, mb_en_d;

  assign dflt_map = base_map_i & cvlan_map_i;
  assign cpu_map  = {{(NPORT-1){1'b0}}, 1'b1} << cpu_port_i;
  assign fwd_eff  = (hit_i && snoop_act_i == 3'd0) ? fwd_act_i : 4'd0;

  always_comb begin
    case (fwd_eff)
      4'd2:    map_d = '0;
      4'd3:    map_d = cpu_map;
      4'd4:    map_d = alt_map_i;
      4'd7:    map_d = base_map_i & alt_map_i;
      4'd8:    map_d = dflt_map & alt_map_i;
      default: map_d = dflt_map;
    endcase
  end

  assign mcast_d = (fwd_eff == 4'd5) || (fwd_eff == 4'd6);

  always_comb begin
    if (!hit_i) learn_d = learn_dflt_i;
    else begin
      case (learn_act_i)
        2'd1:    learn_d = egr_left_i && (map_d != '0);
        2'd2:    learn_d = 1'b0;
        2'd3:    learn_d = 1'b1;
        default: learn_d = learn_dflt_i;
      endcase
    end
  end

  assign tc_d    = (hit_i && tc_act_i == CODE_ON) ? alt_tc_i : cos_tc_i;
  assign ma_en_d = hit_i && meter_act_i[1];
  assign mb_en_d = hit_i && meter_act_i == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      port_map_o <= '0;
      learn_o    <= 1'b0;
      tc_o       <= '0;
      mtr_a_en_o <= 1'b0;
      mtr_a_id_o <= '0;
      mtr_b_en_o <= 1'b0;
      mtr_b_id_o <= '0;
      mcast_o    <= 1'b0;
      snoop_o    <= '0;
      irq_o      <= 1'b0;
      tstamp_o   <= 1'b0;
      crit_o     <= 1'b0;
      xstate_o   <= 1'b0;
      xvlan_o    <= 1'b0;
    end else begin
      valid_o    <= valid_i;
      port_map_o <= map_d;
      learn_o    <= learn_d;
      tc_o       <= tc_d;
      mtr_a_en_o <= ma_en_d;
      mtr_a_id_o <= ma_en_d ? meter_id_i : '0;
      mtr_b_en_o <= mb_en_d;
      mtr_b_id_o <= mb_en_d ? meter_id_i + 1'b1 : '0;
      mcast_o    <= mcast_d;
      snoop_o    <= hit_i ? snoop_act_i : 3'd0;
      irq_o      <= hit_i && irq_act_i == CODE_ON;
      tstamp_o   <= hit_i && tstamp_act_i == CODE_ON;
      crit_o     <= hit_i && crit_act_i == CODE_ON;
      xstate_o   <= hit_i && xstate_act_i == CODE_ON;
      xvlan_o    <= hit_i && xvlan_act_i == CODE_ON;
    end
  end

  assert_miss_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(!hit_i) |-> learn_o == $past(learn_dflt_i) && tc_o == $past(cos_tc_i) && !mtr_a_en_o && !irq_o);

  assert_learn_forced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(hit_i && learn_act_i[1]) |-> learn_o == $past(learn_act_i[0]));

  assert_discard_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(hit_i && snoop_act_i == 3'd0 && fwd_act_i == 4'd2) |-> port_map_o == '0);

  assert_cpu_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && $past(hit_i && snoop_act_i == 3'd0 && fwd_act_i == 4'd3 && cpu_port_i < NPORT)
    |-> $countones(port_map_o) == 1);

  assert_snoop_no_mcast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_o != 3'd0 |-> !mcast_o);

  assert_meter_pair_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mtr_b_en_o |-> mtr_a_en_o && mtr_b_id_o == MIDW'(mtr_a_id_o + 1'b1));

  assert_valid_follow_R14: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(valid_i));

endmodule

// File: tb/sim_class_action_resolver.sv
module sim_class_action_resolver;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8, TW = 4, MW = 5;

  logic clk = 0, rst_n = 0;
  logic valid_i = 0, hit_i = 0;
  logic [2:0] snoop_act_i = 0;
  logic [3:0] fwd_act_i = 0;
  logic [NP-1:0] alt_map_i = 0, base_map_i = 0, cvlan_map_i = 0;
  logic [1:0] learn_act_i = 0, tc_act_i = 0, meter_act_i = 0;
  logic [1:0] irq_act_i = 0, tstamp_act_i = 0, crit_act_i = 0, xstate_act_i = 0, xvlan_act_i = 0;
  logic [TW-1:0] alt_tc_i = 0, cos_tc_i = 0;
  logic [MW-1:0] meter_id_i = 0;
  logic [2:0] cpu_port_i = 0;
  logic learn_dflt_i = 0, egr_left_i = 0;

  logic valid_o, learn_o, mtr_a_en_o, mtr_b_en_o, mcast_o;
  logic irq_o, tstamp_o, crit_o, xstate_o, xvlan_o;
  logic [NP-1:0] port_map_o;
  logic [TW-1:0] tc_o;
  logic [MW-1:0] mtr_a_id_o, mtr_b_id_o;
  logic [2:0] snoop_o;

  class_action_resolver #(.NPORT(NP), .TCW(TW), .MIDW(MW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected values of the frame in flight
  int e_valid, e_map, e_learn, e_tc, e_mae, e_mai, e_mbe, e_mbi, e_mc, e_sn;
  int e_irq, e_ts, e_cr, e_xs, e_xv;
  string t_map, t_misc;

  task automatic model();
    int base, dm;
    base = int'(base_map_i);
    dm = int'(base_map_i) & int'(cvlan_map_i);
    e_valid = valid_i;
    e_mc = 0;
    t_misc = hit_i ? "" : "R1";
    if (!hit_i) begin
      e_map = dm; t_map = "R1";
    end else if (snoop_act_i != 0) begin
      e_map = dm; t_map = "R10";
    end else begin
      case (int'(fwd_act_i))
        2: begin e_map = 0; t_map = "R4"; end
        3: begin e_map = 1 << cpu_port_i; t_map = "R5"; end
        4: begin e_map = int'(alt_map_i); t_map = "R6"; end
        7: begin e_map = base & int'(alt_map_i); t_map = "R7"; end
        8: begin e_map = dm & int'(alt_map_i); t_map = "R8"; end
        5, 6: begin e_map = dm; e_mc = 1; t_map = "R9"; end
        default: begin e_map = dm; t_map = "R3"; end
      endcase
    end
    if (!hit_i || learn_act_i == 0) e_learn = learn_dflt_i;
    else if (learn_act_i == 1) e_learn = (egr_left_i && e_map != 0) ? 1 : 0;
    else e_learn = (learn_act_i == 3) ? 1 : 0;
    e_tc  = (hit_i && tc_act_i == 2) ? int'(alt_tc_i) : int'(cos_tc_i);
    e_mae = (hit_i && meter_act_i >= 2) ? 1 : 0;
    e_mbe = (hit_i && meter_act_i == 3) ? 1 : 0;
    e_mai = e_mae ? int'(meter_id_i) : 0;
    e_mbi = e_mbe ? (int'(meter_id_i) + 1) % (1 << MW) : 0;
    e_sn  = hit_i ? int'(snoop_act_i) : 0;
    e_irq = (hit_i && irq_act_i == 2) ? 1 : 0;
    e_ts  = (hit_i && tstamp_act_i == 2) ? 1 : 0;
    e_cr  = (hit_i && crit_act_i == 2) ? 1 : 0;
    e_xs  = (hit_i && xstate_act_i == 2) ? 1 : 0;
    e_xv  = (hit_i && xvlan_act_i == 2) ? 1 : 0;
  endtask

  task automatic compare();
    chk("R14", "valid", valid_o, e_valid);
    chk(t_map, "port_map", port_map_o, e_map);
    chk(hit_i ? "R2" : "R1", "learn", learn_o, e_learn);
    chk(t_misc == "" ? "R11" : t_misc, "tc", tc_o, e_tc);
    chk("R12", "mtr_a_en", mtr_a_en_o, e_mae);
    chk("R12", "mtr_a_id", mtr_a_id_o, e_mai);
    chk("R12", "mtr_b_en", mtr_b_en_o, e_mbe);
    chk("R12", "mtr_b_id", mtr_b_id_o, e_mbi);
    chk("R9", "mcast", mcast_o, e_mc);
    chk("R10", "snoop", snoop_o, e_sn);
    chk("R13", "irq", irq_o, e_irq);
    chk("R13", "tstamp", tstamp_o, e_ts);
    chk("R13", "crit", crit_o, e_cr);
    chk("R13", "xstate", xstate_o, e_xs);
    chk("R13", "xvlan", xvlan_o, e_xv);
  endtask

  // inputs are driven at negedge; the model uses those values; outputs compared one clock later
  task automatic step();
    bit h;
    model();
    h = hit_i;
    @(posedge clk);
    @(negedge clk);
    hit_i = h;
    compare();
  endtask

  task automatic rnd_frame(int hit_pct);
    valid_i = ($urandom % 8) != 0;
    hit_i = ($urandom % 100) < hit_pct;
    snoop_act_i = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
    fwd_act_i = 4'($urandom); alt_map_i = NP'($urandom);
    learn_act_i = 2'($urandom); tc_act_i = 2'($urandom); alt_tc_i = TW'($urandom);
    meter_act_i = 2'($urandom); meter_id_i = MW'($urandom);
    irq_act_i = 2'($urandom); tstamp_act_i = 2'($urandom); crit_act_i = 2'($urandom);
    xstate_act_i = 2'($urandom); xvlan_act_i = 2'($urandom);
    base_map_i = NP'($urandom); cvlan_map_i = NP'($urandom); cos_tc_i = TW'($urandom);
    cpu_port_i = 3'($urandom); learn_dflt_i = 1'($urandom); egr_left_i = 1'($urandom);
  endtask

  task automatic directed(int fwd, int lrn, bit egr);
    valid_i = 1; hit_i = 1; snoop_act_i = 0;
    fwd_act_i = 4'(fwd); learn_act_i = 2'(lrn); egr_left_i = egr;
    base_map_i = 8'hF3; cvlan_map_i = 8'h3F; alt_map_i = 8'h5A; cpu_port_i = 3'd6;
    learn_dflt_i = 0; tc_act_i = 2; alt_tc_i = 4'hB; cos_tc_i = 4'h2;
    meter_act_i = 3; meter_id_i = 5'h1F;
    irq_act_i = 2; tstamp_act_i = 1; crit_act_i = 3; xstate_act_i = 2; xvlan_act_i = 0;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R14: reset state
    chk("R14", "reset valid", valid_o, 0);
    chk("R14", "reset map", port_map_o, 0);
    chk("R14", "reset learn", learn_o, 0);
    chk("R14", "reset tc", tc_o, 0);
    rst_n = 1;
    @(negedge clk);
    // R3..R9 forwarding codes, R2 learning, R12 meter wrap (1F -> 00)
    for (int c = 0; c < 16; c++) directed(c, 1, 1);
    directed(2, 1, 1);   // R2: discard -> no learn with code 1
    directed(4, 1, 0);   // R2: no egress left
    directed(4, 0, 1);
    directed(3, 2, 1);
    directed(2, 3, 0);   // R2: forced learn despite discard
    // R10: snooping masks forwarding
    directed(2, 1, 1); snoop_act_i = 3'd3; step();
    fwd_act_i = 4'd5; step();
    // R1: miss
    hit_i = 0; step();
    valid_i = 0; step();
    for (int i = 0; i < 600; i++) begin
      rnd_frame(75);
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule